// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit executes the instruction that configures vector length on a scalar core with a vector extension. It keeps a small state register that holds two lengths: the maximum vector length and the current vector length. Each instruction may take a new maximum from its immediate field, and a new current length from the immediate, from a source register or from the current state. The current length is then clamped to the maximum. The clamped length goes back to the destination register, zero-extended, and a mode bit records whether vertical-first operation is selected.

One combination of the flag bits skips the length update. With the vertical flag set and both update flags clear, the unit sends a single-cycle advance pulse to an external element sequencer instead. The issue stage presents an instruction word with a valid strobe, the 64-bit source value, and an indication of whether the source index names register zero. All results are registered and appear one clock after issue.

Top module: `vlcfg_unit`

## Requirements
- R1: An instruction is executed only when the valid strobe is high, the top six bits `insn_i[31:26]` equal the parameter `PO_VAL` (default 22) and the secondary opcode `insn_i[5:1]` is zero. Any other word leaves every output and the state unchanged.
- R2: The length immediate is the 7-bit field `insn_i[15:9]` plus one, kept modulo 128. An immediate field of 0 gives 1, and 127 gives 0.
- R3: With `insn_i[7]` (length-select flag) at 1, the new current length is the immediate when `src_is_r0_i` is 1, and otherwise the low 7 bits of `src_val_i`. With the flag at 0, the stored current length is kept.
- R4: With `insn_i[6]` (maximum-select flag) at 1, the new maximum is the immediate. Otherwise the stored maximum is kept.
- R5: When the new current length exceeds the new maximum, the current length stored and returned equals the maximum.
- R6: `state_o` holds the maximum in bits [13:7] and the current length in bits [6:0]. Both fields are rewritten one cycle after every executed length update.
- R7: One cycle after a length update, `rd_we_o` is high for that cycle. `rd_wdata_o` then carries the clamped length zero-extended to 64 bits, and `rd_idx_o` carries `insn_i[25:21]`.
- R8: A length update sets `vmode_o` to the vertical flag `insn_i[8]`.
- R9: With `insn_i[8]`=1, `insn_i[7]`=0 and `insn_i[6]`=0, the unit raises `step_o` for exactly one cycle. It leaves `state_o`, `vmode_o` and `rd_we_o` unchanged.
- R10: `rec_o` is high together with `rd_we_o` exactly when the record bit `insn_i[0]` of the executed update was 1.
- R11: Synchronous reset clears the state, the mode bit and all pulses to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_vld_i | input | 1 | Instruction valid strobe |
| insn_i | input | 32 | Instruction word |
| src_val_i | input | 64 | Source register value |
| src_is_r0_i | input | 1 | Source index names register zero |
| rd_we_o | output | 1 | Destination write enable pulse |
| rd_idx_o | output | 5 | Destination register index |
| rd_wdata_o | output | 64 | Destination write data (zero-extended length) |
| rec_o | output | 1 | Record request with the destination write |
| state_o | output | 14 | Maximum length [13:7], current length [6:0] |
| vmode_o | output | 1 | Vertical-first mode bit |
| step_o | output | 1 | Advance-element pulse to the sequencer |

## Verification
The bench targets the clamp in both directions. A source value above the maximum must be cut down, and lowering the maximum while keeping the stored length must pull the length down too. A design without the clamp would store a length above the maximum. The immediate wrap at field value 127 is checked, and an adder that is too wide or a missing increment would give 128 or 127 instead of 0. The vertical-step combination must leave the state and mode untouched. A design that falls through to the update path would write the destination and change the lengths. Words with a wrong primary or secondary opcode, and valid words presented with the strobe low, must leave no trace.

// File: rtl/vlcfg_pkg.sv
`timescale 1ns/1ps
package vlcfg_pkg;
  localparam int IMM_W = 7;

  typedef struct packed {
    logic [4:0]       rt;
    logic [IMM_W-1:0] svi;
    logic             vf;
    logic             vs;
    logic             ms;
    logic             rc;
    logic             hit;
    logic             step;
  } vl_op_t;
endpackage

// File: rtl/vlcfg_decode.sv
`timescale 1ns/1ps
module vlcfg_decode #(
  parameter logic [5:0] PO_VAL = 6'd22
) (
  input  logic [31:0]      insn_i,
  output vlcfg_pkg::vl_op_t op_o
);
  // The source index field [20:16] is qualified outside through src_is_r0_i.
  logic unused_ra;
  assign unused_ra = ^insn_i[20:16];

  always_comb begin
    op_o.rt   = insn_i[25:21];
    op_o.svi  = insn_i[15:9];
    op_o.vf   = insn_i[8];
    op_o.vs   = insn_i[7];
    op_o.ms   = insn_i[6];
    op_o.rc   = insn_i[0];
    op_o.hit  = (insn_i[31:26] == PO_VAL) && (insn_i[5:1] == 5'b00000);
    op_o.step = insn_i[8] & ~insn_i[7] & ~insn_i[6];
  end
endmodule

// File: rtl/vlcfg_len.sv
`timescale 1ns/1ps
module vlcfg_len #(
  parameter int LEN_W = 7,
  parameter int XLEN  = 64
) (
  input  logic [LEN_W-1:0] svi_i,
  input  logic             vs_i,
  input  logic             ms_i,
  input  logic             ra_zero_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic [LEN_W-1:0] cur_mvl_i,
  input  logic [LEN_W-1:0] cur_vl_i,
  output logic [LEN_W-1:0] mvl_o,
  output logic [LEN_W-1:0] vl_o
);
  logic [LEN_W-1:0] imm;
  logic [LEN_W-1:0] vl_raw;
  logic             unused_src_hi;

  assign unused_src_hi = ^src_i[XLEN-1:LEN_W];
  assign imm = svi_i + LEN_W'(1);

  always_comb begin
    if (vs_i) vl_raw = ra_zero_i ? imm : src_i[LEN_W-1:0];
    else      vl_raw = cur_vl_i;
    mvl_o = ms_i ? imm : cur_mvl_i;
    vl_o  = (vl_raw > mvl_o) ? mvl_o : vl_raw;
  end
endmodule

// File: rtl/vlcfg_unit.sv
`timescale 1ns/1ps
module vlcfg_unit #(
  parameter int         LEN_W  = 7,
  parameter int         XLEN   = 64,
  parameter logic [5:0] PO_VAL = 6'd22
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 insn_vld_i,
  input  logic [31:0]          insn_i,
  input  logic [XLEN-1:0]      src_val_i,
  input  logic                 src_is_r0_i,
  output logic                 rd_we_o,
  output logic [4:0]           rd_idx_o,
  output logic [XLEN-1:0]      rd_wdata_o,
  output logic                 rec_o,
  output logic [2*LEN_W-1:0]   state_o,
  output logic                 vmode_o,
  output logic                 step_o
);
  localparam int ST_W = 2 * LEN_W;
  localparam int PAD_W = XLEN - LEN_W;

  vlcfg_pkg::vl_op_t op;
  logic [LEN_W-1:0]  nxt_mvl, nxt_vl;
  logic              fire;

  vlcfg_decode #(.PO_VAL(PO_VAL)) u_dec (
    .insn_i (insn_i),
    .op_o   (op)
  );

  vlcfg_len #(.LEN_W(LEN_W), .XLEN(XLEN)) u_len (
    .svi_i     (op.svi),
    .vs_i      (op.vs),
    .ms_i      (op.ms),
    .ra_zero_i (src_is_r0_i),
    .src_i     (src_val_i),
    .cur_mvl_i (state_o[ST_W-1:LEN_W]),
    .cur_vl_i  (state_o[LEN_W-1:0]),
    .mvl_o     (nxt_mvl),
    .vl_o      (nxt_vl)
  );

  assign fire = insn_vld_i & op.hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_we_o    <= 1'b0;
      rd_idx_o   <= '0;
      rd_wdata_o <= '0;
      rec_o      <= 1'b0;
      state_o    <= '0;
      vmode_o    <= 1'b0;
      step_o     <= 1'b0;
    end else begin
      rd_we_o <= 1'b0;
      rec_o   <= 1'b0;
      step_o  <= 1'b0;
      if (fire) begin
        if (op.step) begin
          step_o <= 1'b1;
        end else begin
          state_o    <= {nxt_mvl, nxt_vl};
          rd_wdata_o <= {{PAD_W{1'b0}}, nxt_vl};
          rd_idx_o   <= op.rt;
          rd_we_o    <= 1'b1;
          rec_o      <= op.rc;
          vmode_o    <= op.vf;
        end
      end
    end
  end
endmodule

// File: rtl/vlcfg_chk.sv
`timescale 1ns/1ps
module vlcfg_chk #(
  parameter int LEN_W = 7,
  parameter int XLEN  = 64
) (
  input logic               clk,
  input logic               rst,
  input logic               insn_vld_i,
  input logic               rd_we_o,
  input logic [XLEN-1:0]    rd_wdata_o,
  input logic               rec_o,
  input logic [2*LEN_W-1:0] state_o,
  input logic               vmode_o,
  input logic               step_o
);
  // R5
  vl_le_mvl_chk: assert property (@(posedge clk) disable iff (rst)
    state_o[LEN_W-1:0] <= state_o[2*LEN_W-1:LEN_W]);

  // R7
  wdata_zext_chk: assert property (@(posedge clk) disable iff (rst)
    rd_we_o |-> (rd_wdata_o == {{(XLEN-LEN_W){1'b0}}, state_o[LEN_W-1:0]}));

  // R9
  step_hold_chk: assert property (@(posedge clk) disable iff (rst)
    step_o |-> ($stable(state_o) && $stable(vmode_o) && !rd_we_o));

  // R10
  rec_with_we_chk: assert property (@(posedge clk) disable iff (rst)
    rec_o |-> rd_we_o);

  // R1
  no_issue_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(insn_vld_i) |-> (!rd_we_o && !step_o));
endmodule

bind vlcfg_unit vlcfg_chk #(.LEN_W(LEN_W), .XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .insn_vld_i (insn_vld_i),
  .rd_we_o    (rd_we_o),
  .rd_wdata_o (rd_wdata_o),
  .rec_o      (rec_o),
  .state_o    (state_o),
  .vmode_o    (vmode_o),
  .step_o     (step_o)
);

// File: tb/sim_vlcfg_unit.sv
`timescale 1ns/1ps
module sim_vlcfg_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_vld_i = 1'b0;
  logic [31:0] insn_i = '0;
  logic [63:0] src_val_i = '0;
  logic        src_is_r0_i = 1'b1;
  logic        rd_we_o;
  logic [4:0]  rd_idx_o;
  logic [63:0] rd_wdata_o;
  logic        rec_o;
  logic [13:0] state_o;
  logic        vmode_o;
  logic        step_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vlcfg_unit u0 (
    .clk(clk), .rst(rst), .insn_vld_i(insn_vld_i), .insn_i(insn_i),
    .src_val_i(src_val_i), .src_is_r0_i(src_is_r0_i),
    .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o), .rd_wdata_o(rd_wdata_o),
    .rec_o(rec_o), .state_o(state_o), .vmode_o(vmode_o), .step_o(step_o)
  );

  function automatic logic [31:0] mk(input logic [5:0] po, input logic [4:0] rt,
                                     input logic [6:0] svi, input logic vf,
                                     input logic vs, input logic ms,
                                     input logic [4:0] xo, input logic rc);
    return {po, rt, 5'd3, svi, vf, vs, ms, xo, rc};
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] src,
                       input logic r0, input logic vld);
    @(negedge clk);
    insn_i = w; src_val_i = src; src_is_r0_i = r0; insn_vld_i = vld;
    @(posedge clk);
    @(negedge clk);
    insn_vld_i = 1'b0;
  endtask

  task automatic upd(input string req, input logic [31:0] w, input logic [63:0] src,
                     input logic r0, input int mvl, input int vl,
                     input logic vm, input logic rc);
    issue(w, src, r0, 1'b1);
    chk(req, "we", 64'(rd_we_o), 64'd1);
    chk(req, "state", 64'(state_o), 64'({7'(mvl), 7'(vl)}));
    chk(req, "wdata", rd_wdata_o, 64'(vl));
    chk(req, "idx", 64'(rd_idx_o), 64'(w[25:21]));
    chk(req, "vmode", 64'(vmode_o), 64'(vm));
    chk(req, "rec", 64'(rec_o), 64'(rc));
  endtask

  task automatic quiet(input string req, input logic [31:0] w, input logic vld);
    logic [13:0] st; logic vm;
    st = state_o; vm = vmode_o;
    issue(w, 64'h7f, 1'b0, vld);
    chk(req, "we", 64'(rd_we_o), 64'd0);
    chk(req, "step", 64'(step_o), 64'd0);
    chk(req, "state", 64'(state_o), 64'(st));
    chk(req, "vmode", 64'(vmode_o), 64'(vm));
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    chk("R11", "state", 64'(state_o), 64'd0);
    chk("R11", "we", 64'(rd_we_o), 64'd0);
    chk("R11", "vmode", 64'(vmode_o), 64'd0);
    chk("R11", "step", 64'(step_o), 64'd0);
  endtask

  task automatic t_step;
    issue(mk(6'd22, 5'd4, 7'd50, 1'b1, 1'b0, 1'b0, 5'd0, 1'b1), 64'd3, 1'b0, 1'b1);
    chk("R9", "step", 64'(step_o), 64'd1);
    chk("R9", "we", 64'(rd_we_o), 64'd0);
    chk("R9", "state", 64'(state_o), 64'({7'd21, 7'd21}));
    chk("R9", "vmode", 64'(vmode_o), 64'd1);
    @(negedge clk);
    chk("R9", "step one cycle", 64'(step_o), 64'd0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    // R2 R3 R4: immediate 9+1 to both lengths
    upd("R2", mk(6'd22, 5'd1, 7'd9, 1'b0, 1'b1, 1'b1, 5'd0, 1'b0), 64'd0, 1'b1, 10, 10, 1'b0, 1'b0);
    // R3: low bits of source, maximum kept
    upd("R3", mk(6'd22, 5'd2, 7'd0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0), 64'hFFFF_FFFF_FFFF_FF85, 1'b0, 10, 5, 1'b0, 1'b0);
    // R5: source 50 clamped to 10
    upd("R5", mk(6'd22, 5'd3, 7'd0, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0), 64'd50, 1'b0, 10, 10, 1'b0, 1'b0);
    // R4 R5: new maximum 4 pulls kept length 10 down
    upd("R4", mk(6'd22, 5'd4, 7'd3, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0), 64'd0, 1'b0, 4, 4, 1'b0, 1'b0);
    // R3: register-zero selects immediate 2
    upd("R3", mk(6'd22, 5'd5, 7'd1, 1'b0, 1'b1, 1'b0, 5'd0, 1'b0), 64'd99, 1'b1, 4, 2, 1'b0, 1'b0);
    // R10 R6: both kept, record flag
    upd("R10", mk(6'd22, 5'd6, 7'd60, 1'b0, 1'b0, 1'b0, 5'd0, 1'b1), 64'd0, 1'b0, 4, 2, 1'b0, 1'b1);
    // R8: vertical flag with update
    upd("R8", mk(6'd22, 5'd7, 7'd20, 1'b1, 1'b1, 1'b1, 5'd0, 1'b0), 64'd0, 1'b1, 21, 21, 1'b1, 1'b0);
    t_step();
    // R1: wrong primary opcode, wrong secondary opcode, strobe low
    quiet("R1", mk(6'd23, 5'd1, 7'd5, 1'b0, 1'b1, 1'b1, 5'd0, 1'b0), 1'b1);
    quiet("R1", mk(6'd22, 5'd1, 7'd5, 1'b1, 1'b0, 1'b0, 5'd1, 1'b0), 1'b1);
    quiet("R1", mk(6'd22, 5'd1, 7'd5, 1'b0, 1'b1, 1'b1, 5'd0, 1'b0), 1'b0);
    // R2 R8: immediate 127 wraps to 0, vertical mode cleared
    upd("R2", mk(6'd22, 5'd9, 7'd127, 1'b0, 1'b1, 1'b1, 5'd0, 1'b0), 64'd0, 1'b1, 0, 0, 1'b0, 1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule